// File: doc/BRIEF.md
# Triple-Byte Boot Image Streamer

This block pushes a boot or program image into an attached processor whose host port takes each 24-bit word as three separate byte writes. The image reaches the block as a byte stream with valid/ready handshake; the total byte count is given with a start pulse. Before anything moves, the block checks the image shape. The first word carries a length header that must agree with the declared size. It then sends every word, header included, only after it has polled the target's status register and seen the transmit-ready flag.

Each word is assembled from three incoming bytes and held until the target is ready. If the flag does not come up within a timeout window, the transfer aborts and reports the byte offset of the stuck word. After the final word a settling wait runs before completion is flagged. All intervals are counted in clock cycles and set by parameters.

Top module: `boot_image_streamer`

## Requirements
- R1: After reset the block is idle: `busy`, `inReady`, `regRdEn`, `regWrEn`, `done` and `err` are all low.
- R2: A start with a byte count of zero, or one not divisible by 3, ends with `err` and `errCode` = 1 (size fault), `errPos` = 0. No byte is accepted and no register is accessed.
- R3: The first three bytes form the length L, most significant byte first. The image is accepted only if L = 0 or the byte count equals (L+2)*3. Otherwise `err` fires with `errCode` = 2 (header fault) and `errPos` = 0, after exactly 3 bytes are taken and with no write.
- R4: Before each word the block reads the status register (offset `STATUS_OFS`) until bit `RDY_BIT` (2) reads 1. No word write begins unless the read just before it returned that bit set.
- R5: A word goes out as three writes in consecutive cycles, in a fixed order: the high byte to `TX_OFS`, the middle byte to `TX_OFS`+1, then the low byte to `TX_OFS`+2.
- R6: The header word is written to the target like every other word. A valid image produces exactly one write per image byte, in image order.
- R7: If the ready bit stays clear for more than `TIMEOUT_CYC` cycles of polling, `err` fires with `errCode` = 3 (ready timeout) and `errPos` = the byte offset of the word being sent. Earlier words have already been written.
- R8: `done` pulses for one cycle exactly `SETTLE_CYC` cycles after the cycle of the final low-byte write. `done` and `err` are never high together.
- R9: `inReady` is high only while a word is being collected. It is never high during a register access, and a run consumes exactly the bytes up to and including the last word it reached.
- R10: A `start` while `busy` is high is ignored. The run in progress completes with its original byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer, sampled when idle |
| imgSize | input | SIZE_W | Total image byte count, captured on start |
| inData | input | 8 | Image byte |
| inValid | input | 1 | Image byte present |
| inReady | output | 1 | Block takes the byte this cycle |
| regAddr | output | ADDR_W | Target register offset |
| regRdEn | output | 1 | Status read strobe; data is used on the following cycle |
| regWrEn | output | 1 | Data byte write strobe |
| regWrData | output | 8 | Byte being written |
| regRdData | input | 8 | Status byte returned by the target |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle abort pulse |
| errCode | output | 2 | 0 none, 1 size, 2 header, 3 ready timeout |
| errPos | output | SIZE_W | Byte offset of the failing word |

## Verification
The bench aims at a header written low byte first. A design that assembled the length in the wrong byte order would accept it, or would reject a good image. It also feeds a header whose length disagrees by one word, where a loose size compare would let the image through. A target that only raises ready after several polls, plus one that never does, checks that no write slips out early. The same cases check that a timeout reports the stuck word's offset and not zero or the next word's offset. A start pulse in the middle of a run, and the cycle distance from the last write to `done`, catch a design that restarts or miscounts the settling wait.

// File: rtl/bis_pkg.sv
package bis_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 3;
  localparam int WORD_W     = BYTE_W * WORD_BYTES;

  typedef enum logic [1:0] {
    FAULT_NONE    = 2'd0,
    FAULT_SIZE    = 2'd1,
    FAULT_HEADER  = 2'd2,
    FAULT_TIMEOUT = 2'd3
  } fault_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CHECK, ST_FETCH, ST_POLL, ST_WAIT,
    ST_WR_HI, ST_WR_MID, ST_WR_LO, ST_SETTLE, ST_FAIL
  } state_e;

  typedef struct packed {
    logic       capture;
    logic       takeByte;
    logic       advance;
    logic       clrTimer;
    logic [1:0] wrSel;
    logic       setErr;
    fault_e     errKind;
  } ctlStrobes_t;
endpackage

// File: rtl/bis_datapath.sv
module bis_datapath
  import bis_pkg::*;
#(
  parameter int SIZE_W      = 24,
  parameter int TIMEOUT_CYC = 20000000,
  parameter int SETTLE_CYC  = 200000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [SIZE_W-1:0] imgSize,
  input  logic [BYTE_W-1:0] inData,
  output logic [BYTE_W-1:0] regWrData,
  output logic              sizeBad,
  output logic              hdrBad,
  output logic              wordFull,
  output logic              isFirst,
  output logic              isLast,
  output logic              pollExpired,
  output logic              settleDone,
  output logic [1:0]        errCode,
  output logic [SIZE_W-1:0] errPos
);
  localparam int LIMIT = (TIMEOUT_CYC > SETTLE_CYC) ? TIMEOUT_CYC : SETTLE_CYC;
  localparam int TMR_W = $clog2(LIMIT + 1) + 1;
  localparam int CMP_W = (SIZE_W > WORD_W + 3) ? SIZE_W : WORD_W + 3;

  logic [SIZE_W-1:0] sizeQ, posQ, errPosQ;
  logic [WORD_W-1:0] wordQ;
  logic [1:0]        byteCnt;
  logic [TMR_W-1:0]  timerQ;
  fault_e            errCodeQ;
  logic [CMP_W-1:0]  needBytes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sizeQ    <= '0;
      posQ     <= '0;
      wordQ    <= '0;
      byteCnt  <= '0;
      timerQ   <= '0;
      errCodeQ <= FAULT_NONE;
      errPosQ  <= '0;
    end else begin
      if (ctl.capture) begin
        sizeQ    <= imgSize;
        posQ     <= '0;
        byteCnt  <= '0;
        errCodeQ <= FAULT_NONE;
        errPosQ  <= '0;
      end
      if (ctl.takeByte) begin
        wordQ   <= {wordQ[WORD_W-BYTE_W-1:0], inData};
        byteCnt <= byteCnt + 2'd1;
      end
      if (ctl.advance) begin
        posQ    <= posQ + SIZE_W'(WORD_BYTES);
        byteCnt <= '0;
      end
      if (ctl.clrTimer)       timerQ <= '0;
      else if (timerQ != '1)  timerQ <= timerQ + 1'b1;
      if (ctl.setErr) begin
        errCodeQ <= ctl.errKind;
        errPosQ  <= posQ;
      end
    end
  end

  assign needBytes   = (CMP_W'(wordQ) + CMP_W'(2)) * CMP_W'(WORD_BYTES);
  assign hdrBad      = (wordQ != '0) && (needBytes != CMP_W'(sizeQ));
  assign sizeBad     = (sizeQ == '0) || ((sizeQ % SIZE_W'(WORD_BYTES)) != '0);
  assign wordFull    = (byteCnt == 2'(WORD_BYTES));
  assign isFirst     = (posQ == '0);
  assign isLast      = ((posQ + SIZE_W'(WORD_BYTES)) == sizeQ);
  assign pollExpired = (timerQ >= TMR_W'(TIMEOUT_CYC));
  assign settleDone  = (timerQ == TMR_W'(SETTLE_CYC - 1));
  assign regWrData   = wordQ[BYTE_W*ctl.wrSel +: BYTE_W];
  assign errCode     = errCodeQ;
  assign errPos      = errPosQ;

  // R3: a first word is only released when its header agreed with the size
  a_r3_header_checked: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && isFirst) |-> !hdrBad);
  // R9: no byte is taken into a word that is already complete
  a_r9_no_overfill: assert property (@(posedge clk) disable iff (!rstN)
    ctl.takeByte |-> !wordFull);
endmodule

// File: rtl/bis_control.sv
module bis_control
  import bis_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int STATUS_OFS = 2,
  parameter int TX_OFS     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              inValid,
  input  logic              rdy,
  input  logic              sizeBad,
  input  logic              hdrBad,
  input  logic              wordFull,
  input  logic              isFirst,
  input  logic              isLast,
  input  logic              pollExpired,
  input  logic              settleDone,
  output ctlStrobes_t       ctl,
  output logic              inReady,
  output logic              regRdEn,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regAddr,
  output logic              busy,
  output logic              done,
  output logic              err
);
  state_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD  = stateQ;
    ctl     = '0;
    inReady = 1'b0;
    regRdEn = 1'b0;
    regWrEn = 1'b0;
    regAddr = '0;
    done    = 1'b0;
    err     = 1'b0;
    unique case (stateQ)
      ST_IDLE: if (start) begin
        ctl.capture = 1'b1;
        stateD      = ST_CHECK;
      end
      ST_CHECK: if (sizeBad) begin
        ctl.setErr  = 1'b1;
        ctl.errKind = FAULT_SIZE;
        stateD      = ST_FAIL;
      end else begin
        stateD = ST_FETCH;
      end
      ST_FETCH: begin
        inReady      = !wordFull;
        ctl.takeByte = inValid && !wordFull;
        if (wordFull) begin
          if (isFirst && hdrBad) begin
            ctl.setErr  = 1'b1;
            ctl.errKind = FAULT_HEADER;
            stateD      = ST_FAIL;
          end else begin
            ctl.clrTimer = 1'b1;
            stateD       = ST_POLL;
          end
        end
      end
      ST_POLL: begin
        regRdEn = 1'b1;
        regAddr = ADDR_W'(STATUS_OFS);
        stateD  = ST_WAIT;
      end
      ST_WAIT: if (rdy) begin
        stateD = ST_WR_HI;
      end else if (pollExpired) begin
        ctl.setErr  = 1'b1;
        ctl.errKind = FAULT_TIMEOUT;
        stateD      = ST_FAIL;
      end else begin
        stateD = ST_POLL;
      end
      ST_WR_HI: begin
        regWrEn   = 1'b1;
        regAddr   = ADDR_W'(TX_OFS);
        ctl.wrSel = 2'd2;
        stateD    = ST_WR_MID;
      end
      ST_WR_MID: begin
        regWrEn   = 1'b1;
        regAddr   = ADDR_W'(TX_OFS + 1);
        ctl.wrSel = 2'd1;
        stateD    = ST_WR_LO;
      end
      ST_WR_LO: begin
        regWrEn     = 1'b1;
        regAddr     = ADDR_W'(TX_OFS + 2);
        ctl.wrSel   = 2'd0;
        ctl.advance = 1'b1;
        if (isLast) begin
          ctl.clrTimer = 1'b1;
          stateD       = ST_SETTLE;
        end else begin
          stateD = ST_FETCH;
        end
      end
      ST_SETTLE: if (settleDone) begin
        done   = 1'b1;
        stateD = ST_IDLE;
      end
      ST_FAIL: begin
        err    = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign busy = (stateQ != ST_IDLE);

  // R4: a high-byte write follows a status read that showed ready
  a_r4_write_after_ready: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(TX_OFS)) |-> $past(rdy));
  // R5: high byte is followed by middle byte, middle by low byte
  a_r5_hi_then_mid: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(TX_OFS)) |=> (regWrEn && regAddr == ADDR_W'(TX_OFS + 1)));
  a_r5_mid_then_lo: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(TX_OFS + 1)) |=> (regWrEn && regAddr == ADDR_W'(TX_OFS + 2)));
  // R8: completion and abort never coincide
  a_r8_done_err_apart: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, err}));
  // R9: byte intake never overlaps a register access
  a_r9_intake_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (!regWrEn && !regRdEn));
endmodule

// File: rtl/boot_image_streamer.sv
module boot_image_streamer
  import bis_pkg::*;
#(
  parameter int SIZE_W      = 24,
  parameter int ADDR_W      = 4,
  parameter int STATUS_OFS  = 2,
  parameter int TX_OFS      = 5,
  parameter int RDY_BIT     = 2,
  parameter int TIMEOUT_CYC = 20000000,
  parameter int SETTLE_CYC  = 200000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [SIZE_W-1:0] imgSize,
  input  logic [7:0]        inData,
  input  logic              inValid,
  output logic              inReady,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regRdEn,
  output logic              regWrEn,
  output logic [7:0]        regWrData,
  input  logic [7:0]        regRdData,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        errCode,
  output logic [SIZE_W-1:0] errPos
);
  ctlStrobes_t ctl;
  logic sizeBad, hdrBad, wordFull, isFirst, isLast, pollExpired, settleDone;

  bis_control #(
    .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS), .TX_OFS(TX_OFS)
  ) control_i (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid),
    .rdy(regRdData[RDY_BIT]), .sizeBad(sizeBad), .hdrBad(hdrBad),
    .wordFull(wordFull), .isFirst(isFirst), .isLast(isLast),
    .pollExpired(pollExpired), .settleDone(settleDone), .ctl(ctl),
    .inReady(inReady), .regRdEn(regRdEn), .regWrEn(regWrEn),
    .regAddr(regAddr), .busy(busy), .done(done), .err(err)
  );

  bis_datapath #(
    .SIZE_W(SIZE_W), .TIMEOUT_CYC(TIMEOUT_CYC), .SETTLE_CYC(SETTLE_CYC)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .imgSize(imgSize), .inData(inData),
    .regWrData(regWrData), .sizeBad(sizeBad), .hdrBad(hdrBad),
    .wordFull(wordFull), .isFirst(isFirst), .isLast(isLast),
    .pollExpired(pollExpired), .settleDone(settleDone),
    .errCode(errCode), .errPos(errPos)
  );
endmodule

// File: tb/boot_image_streamer_tb_top.sv
module boot_image_streamer_tb_top;
  localparam int SW = 24;
  localparam int AW = 4;
  localparam int STATUS = 2;
  localparam int TX = 5;
  localparam int TO = 40;
  localparam int ST = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [SW-1:0] imgSize = '0;
  logic [7:0]    inData = '0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [AW-1:0] regAddr;
  logic          regRdEn, regWrEn;
  logic [7:0]    regWrData;
  logic [7:0]    regRdData = '0;
  logic          busy, done, err;
  logic [1:0]    errCode;
  logic [SW-1:0] errPos;

  boot_image_streamer #(
    .SIZE_W(SW), .ADDR_W(AW), .STATUS_OFS(STATUS), .TX_OFS(TX),
    .RDY_BIT(2), .TIMEOUT_CYC(TO), .SETTLE_CYC(ST)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .imgSize(imgSize),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .regAddr(regAddr), .regRdEn(regRdEn), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .busy(busy),
    .done(done), .err(err), .errCode(errCode), .errPos(errPos)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0]  srcQ[$];
  logic [11:0] expQ[$];
  int  cyc = 0, curWord = 0, pollCnt = 0, stuckWord = -1, accepted = 0;
  int  lastWrCyc = 0, gotCode = 0, gotPos = 0;
  bit  pendHs = 0, lastRdy = 0, doneSeen = 0, errSeen = 0, gapMode = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference model of target and byte source, evaluated once per cycle
  initial forever begin
    @(negedge clk);
    cyc++;
    if (rstN) begin
      if (regWrEn) begin
        if (expQ.size() == 0) chk(0, "R6 unexpected write", {regAddr, regWrData}, 0);
        else begin
          chk({regAddr, regWrData} == expQ[0], "R5/R6 write addr+data", {regAddr, regWrData}, expQ[0]);
          void'(expQ.pop_front());
        end
        if (regAddr == AW'(TX)) begin
          chk(lastRdy, "R4 write without ready", 0, 1);
          curWord++;
          pollCnt = 0;
          lastRdy = 0;
        end
        lastWrCyc = cyc;
      end
      if (regRdEn) begin
        bit rd;
        chk(regAddr == AW'(STATUS), "R4 status offset", regAddr, STATUS);
        rd = (curWord != stuckWord) && (pollCnt >= curWord % 3);
        if (!rd) pollCnt++;
        regRdData = {5'b0, rd, 2'b0};
        lastRdy = rd;
      end
      if (done) begin
        doneSeen = 1;
        chk(cyc - lastWrCyc == ST, "R8 settle distance", cyc - lastWrCyc, ST);
      end
      if (err) begin
        errSeen = 1;
        gotCode = errCode;
        gotPos = errPos;
      end
      if (inReady && (regWrEn || regRdEn)) chk(0, "R9 intake during access", 1, 0);
      if (pendHs) begin
        void'(srcQ.pop_front());
        accepted++;
      end
      inValid = (srcQ.size() > 0) && !(gapMode && (cyc % 4 == 3));
      inData  = (srcQ.size() > 0) ? srcQ[0] : 8'h00;
      pendHs  = inValid && inReady;
    end
  end

  task automatic runCase(input string name, input int size, input int stuck,
                         input int expCode, input int expPos, input int nWords,
                         input int expTaken, input bit midStart);
    for (int i = 0; i < nWords * 3 && i < srcQ.size(); i++)
      expQ.push_back({AW'(TX + (i % 3)), srcQ[i]});
    curWord = 0; pollCnt = 0; stuckWord = stuck; accepted = 0;
    doneSeen = 0; errSeen = 0; lastRdy = 0;
    @(negedge clk);
    start = 1'b1;
    imgSize = SW'(size);
    @(negedge clk);
    start = 1'b0;
    if (midStart) begin
      repeat (8) @(negedge clk);
      chk(busy == 1'b1, "R10 busy mid-run", busy, 1);
      start = 1'b1;
      imgSize = '0;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 5000 && !(doneSeen || errSeen); i++) @(negedge clk);
    if (expCode == 0) begin
      chk(doneSeen && !errSeen, {"R8 completion ", name}, errSeen, 0);
    end else begin
      chk(errSeen, {"R2/R3/R7 abort seen ", name}, errSeen, 1);
      chk(gotCode == expCode, {"R2/R3/R7 code ", name}, gotCode, expCode);
      chk(gotPos == expPos, {"R7 error position ", name}, gotPos, expPos);
    end
    chk(expQ.size() == 0, {"R6 all words written ", name}, expQ.size(), 0);
    chk(accepted == expTaken, {"R9 bytes consumed ", name}, accepted, expTaken);
    @(negedge clk);
    chk(!busy && !inReady, {"R1 idle after ", name}, busy, 0);
    srcQ.delete();
    expQ.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !inReady && !regRdEn && !regWrEn && !done && !err, "R1 reset state",
        {busy, inReady, regRdEn, regWrEn, done, err}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !inReady, "R1 idle after reset release", busy, 0);

    // R2: zero size, then a size not divisible by three
    srcQ = '{8'h00, 8'h00, 8'h00};
    runCase("size0", 0, -1, 1, 0, 0, 0, 0);
    srcQ = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h03, 8'h04};
    runCase("size7", 7, -1, 1, 0, 0, 0, 0);

    // R6: zero header, three words, target always ready at first poll for word 0
    srcQ = '{8'h00, 8'h00, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    runCase("hdr0", 9, -1, 0, 0, 3, 9, 0);

    // R3/R4/R10: L=2 with size 12, input gaps, delayed ready, stray start
    gapMode = 1;
    srcQ = '{8'h00, 8'h00, 8'h02, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5, 8'hF6,
             8'h17, 8'h28, 8'h39};
    runCase("hdr2", 12, -1, 0, 0, 4, 12, 1);
    gapMode = 0;

    // R3: header off by one word
    srcQ = '{8'h00, 8'h00, 8'h03, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06,
             8'h07, 8'h08, 8'h09};
    runCase("hdrBad", 12, -1, 2, 0, 0, 3, 0);

    // R3: length written low byte first is rejected
    srcQ = '{8'h02, 8'h00, 8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06,
             8'h07, 8'h08, 8'h09};
    runCase("hdrEndian", 12, -1, 2, 0, 0, 3, 0);

    // R7: target never ready for word 2
    srcQ = '{8'h00, 8'h00, 8'h00, 8'h31, 8'h32, 8'h33, 8'h41, 8'h42, 8'h43,
             8'h51, 8'h52, 8'h53};
    runCase("timeout", 12, 2, 3, 6, 2, 9, 0);

    // recovery after an abort
    srcQ = '{8'h00, 8'h00, 8'h00, 8'h9A, 8'hBC, 8'hDE};
    runCase("recover", 6, -1, 0, 0, 2, 6, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule